// File: doc/BRIEF.md
# Epoch-ordered persist writeback controller

This block is the tag-side controller of a small, fully associative write-back store that sits in front of non-volatile memory and is shared by two CPUs. Each CPU numbers its stores with an epoch counter. An epoch barrier from that CPU closes the current epoch. Every pending (dirty, not yet persisted) line remembers which CPU wrote it and in which epoch. Lines of one epoch may reach memory in any order. A line of a later epoch may reach memory only after every earlier epoch of the same CPU has been written back.

Requests arrive on one CPU port that carries store, load, barrier and evict operations, each with a CPU number and a line tag. When a request would break persist ordering, the controller holds the port not-ready. It then drains a chain of writebacks on a valid/ready stream, oldest epoch first, and only then accepts the request. This happens when evicting a young line, overwriting a line from an older epoch, touching another CPU's pending line, running out of free slots, or running out of epoch numbers. The block stores no data. Each writeback names the tag, the owning CPU and the epoch, so that a data path can move the line.

Top module: `pwc_persist_ctrl`

## Requirements
- R1: After reset no line is pending, `wb_valid` is low and `req_ready` is high. Both CPUs start in epoch 0.
- R2: `req_op` encodes 00 = store, 01 = load, 10 = barrier, 11 = evict. A store that misses takes the lowest free slot and marks it pending, tagged with the storing CPU and that CPU's current epoch. A store by the same CPU to a line it holds pending in the current epoch is accepted with no writeback.
- R3: A barrier advances the CPU's epoch by one, modulo 2^EPOCH_W, only if that CPU had a store accepted since its previous barrier. Otherwise the barrier is accepted with no effect.
- R4: Evicting a pending line is accepted after exactly that line is written back, provided no pending line of the same CPU belongs to an earlier epoch. Other lines stay pending.
- R5: Evicting a pending line whose CPU still holds pending lines of earlier epochs first writes back all of those lines, in ascending epoch order, and then writes back the victim. Other lines in the victim's epoch stay pending.
- R6: A store by a CPU that hits its own pending line from an earlier epoch first writes back every pending line of that CPU up to and including that epoch. The store is then accepted and allocates a fresh line in the current epoch.
- R7: A load or store by one CPU that hits a line pending for the other CPU first writes back the other CPU's pending lines up to and including that line's epoch. A load by the owning CPU, or a load or evict that misses, is accepted with no writeback.
- R8: `req_ready` stays low from the cycle a request needs writebacks until they are complete. Exactly one line is written back per `wb_valid`/`wb_ready` handshake. The writeback fields stay stable while `wb_valid` is high and `wb_ready` is low. Within one epoch, lines leave in ascending slot order.
- R9: A store that misses when every slot is pending first writes back the line in slot 0 together with every pending line of its CPU in that line's epoch or earlier. The store then takes the freed slot.
- R10: A barrier that would make a CPU's current epoch lap its oldest pending epoch (a difference of 2^EPOCH_W-1) first writes back that CPU's oldest epoch. The barrier is accepted only after the oldest pointer has moved past the drained epoch.
- R11: A writeback is never issued while a line of the same CPU from an earlier epoch is still pending. Epoch age is measured modulo 2^EPOCH_W from the CPU's oldest pending epoch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Request accepted on this cycle when high with `req_valid` |
| req_op | input | 2 | Operation: 00 store, 01 load, 10 barrier, 11 evict |
| req_cpu | input | CW | Issuing CPU number |
| req_tag | input | TAG_W | Line tag (ignored for barrier) |
| wb_valid | output | 1 | Writeback request present |
| wb_ready | input | 1 | Memory side takes the writeback |
| wb_tag | output | TAG_W | Tag of the line being written back |
| wb_cpu | output | CW | CPU that wrote the line |
| wb_epoch | output | EPOCH_W | Epoch the line was written in |

## Verification
The bench goes after the chained flushes: evicting a young line, overwriting a line from an old epoch, touching the other CPU's pending line, and a store into a full table. A design that drained only the victim, or drained in slot order instead of epoch order, would show a wrong writeback sequence. A barrier with no store between is checked through the epoch tagged on later writebacks, which would be off by one if the counter advanced anyway. The epoch-wrap case runs with a 2-bit epoch, where a wrong age comparison would send epoch 0 ahead of epochs 1 to 3. Writebacks are stalled at random points, so a design that changed its fields while waiting would show up.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    typedef enum logic [1:0] {
        OP_STORE   = 2'b00,
        OP_LOAD    = 2'b01,
        OP_BARRIER = 2'b10,
        OP_EVICT   = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } phase_e;
endpackage

// File: rtl/pwc_epoch_track.sv
// Per-CPU epoch state: current epoch, oldest epoch still holding pending
// lines, and whether a store landed since the last barrier.
module pwc_epoch_track #(
    parameter int EPOCH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               store_i,
    input  logic               adv_i,
    input  logic               oldest_busy_i,
    output logic [EPOCH_W-1:0] cur_o,
    output logic [EPOCH_W-1:0] oldest_o,
    output logic               stored_o
);
    localparam logic [EPOCH_W-1:0] SPAN_MAX = '1;

    typedef struct packed {
        logic [EPOCH_W-1:0] cur;
        logic [EPOCH_W-1:0] old;
        logic               stored;
    } trk_t;

    trk_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (adv_i) begin
            s_d.cur    = s_q.cur + 1'b1;
            s_d.stored = 1'b0;
        end else if (store_i) begin
            s_d.stored = 1'b1;
        end
        // move the oldest pointer once its epoch has no pending lines left
        if ((s_q.old != s_q.cur) && !oldest_busy_i) begin
            s_d.old = s_q.old + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_o    = s_q.cur;
    assign oldest_o = s_q.old;
    assign stored_o = s_q.stored;

    // R3: the controller only advances an epoch that received a store
    p_adv_needs_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> s_q.stored);

    // R10: an advance never lets the current epoch lap the oldest one
    p_span_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> ((s_q.cur - s_q.old) != SPAN_MAX));
endmodule

// File: rtl/pwc_age_pick.sv
// Chooses, among marked lines, the one with the smallest epoch age;
// ties go to the lowest slot.
module pwc_age_pick #(
    parameter int LINES   = 4,
    parameter int EPOCH_W = 4,
    localparam int IW     = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic [LINES-1:0]               mark_i,
    input  logic [LINES-1:0][EPOCH_W-1:0]  age_i,
    output logic                           any_o,
    output logic [IW-1:0]                  idx_o
);
    logic [EPOCH_W-1:0] best;

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        best  = '0;
        for (int i = 0; i < LINES; i++) begin
            if (mark_i[i] && (!any_o || (age_i[i] < best))) begin
                any_o = 1'b1;
                idx_o = IW'(i);
                best  = age_i[i];
            end
        end
    end
endmodule

// File: rtl/pwc_persist_ctrl.sv
module pwc_persist_ctrl
    import pwc_pkg::*;
#(
    parameter int NCPU    = 2,
    parameter int LINES   = 4,
    parameter int TAG_W   = 8,
    parameter int EPOCH_W = 4,
    localparam int CW     = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int IW     = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic [CW-1:0]      req_cpu,
    input  logic [TAG_W-1:0]   req_tag,
    output logic               wb_valid,
    input  logic               wb_ready,
    output logic [TAG_W-1:0]   wb_tag,
    output logic [CW-1:0]      wb_cpu,
    output logic [EPOCH_W-1:0] wb_epoch
);
    localparam logic [EPOCH_W-1:0] SPAN_MAX = '1;

    typedef struct packed {
        logic [LINES-1:0]              pend;
        logic [LINES-1:0]              mark;
        logic [LINES-1:0][TAG_W-1:0]   tag;
        logic [LINES-1:0][CW-1:0]      own;
        logic [LINES-1:0][EPOCH_W-1:0] ep;
        phase_e                        phase;
    } st_t;

    st_t s_q, s_d;

    logic [EPOCH_W-1:0] cur_ep [NCPU];
    logic [EPOCH_W-1:0] old_ep [NCPU];
    logic [NCPU-1:0]    stored;
    logic [NCPU-1:0]    busy;
    logic [NCPU-1:0]    store_vec;
    logic [NCPU-1:0]    adv_vec;

    logic [LINES-1:0][EPOCH_W-1:0] age;
    logic                          pick_any;
    logic [IW-1:0]                 pick_idx;

    op_e                op;
    logic [LINES-1:0]   hit_vec;
    logic               hit_any, free_any, need, acc, ready_c;
    logic [IW-1:0]      hit_idx, free_idx;
    logic [CW-1:0]      sel_cpu;
    logic [EPOCH_W-1:0] sel_age;
    logic               sel_incl;
    logic [LINES-1:0]   sel_one;
    logic [LINES-1:0]   fmark;

    // epoch age of each line relative to its owner's oldest pending epoch
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            age[i] = s_q.ep[i] - old_ep[s_q.own[i]];
        end
    end

    // an epoch is busy while any pending line of that CPU still carries it
    always_comb begin
        busy = '0;
        for (int c = 0; c < NCPU; c++) begin
            for (int i = 0; i < LINES; i++) begin
                if (s_q.pend[i] && (s_q.own[i] == CW'(c)) && (s_q.ep[i] == old_ep[c])) begin
                    busy[c] = 1'b1;
                end
            end
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        pwc_epoch_track #(.EPOCH_W(EPOCH_W)) u_trk (
            .clk           (clk),
            .rst_n         (rst_n),
            .store_i       (store_vec[c]),
            .adv_i         (adv_vec[c]),
            .oldest_busy_i (busy[c]),
            .cur_o         (cur_ep[c]),
            .oldest_o      (old_ep[c]),
            .stored_o      (stored[c])
        );
    end

    pwc_age_pick #(.LINES(LINES), .EPOCH_W(EPOCH_W)) u_pick (
        .mark_i (s_q.mark),
        .age_i  (age),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    always_comb begin
        s_d = s_q;
        op  = op_e'(req_op);

        // lookup: matching pending line and lowest free slot
        hit_vec  = '0;
        hit_any  = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            hit_vec[i] = s_q.pend[i] && (s_q.tag[i] == req_tag);
            if (hit_vec[i] && !hit_any) begin
                hit_any = 1'b1;
                hit_idx = IW'(i);
            end
            if (!s_q.pend[i] && !free_any) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end

        // decide whether the request first needs an ordered drain
        need     = 1'b0;
        sel_cpu  = s_q.own[hit_idx];
        sel_age  = age[hit_idx];
        sel_incl = 1'b1;
        sel_one  = '0;
        case (op)
            OP_STORE: begin
                if (hit_any) begin
                    need = (s_q.own[hit_idx] != req_cpu) ||
                           (s_q.ep[hit_idx] != cur_ep[req_cpu]);
                end else if (!free_any) begin
                    need    = 1'b1;
                    sel_cpu = s_q.own[0];
                    sel_age = age[0];
                end
            end
            OP_LOAD: begin
                need = hit_any && (s_q.own[hit_idx] != req_cpu);
            end
            OP_EVICT: begin
                if (hit_any) begin
                    need     = 1'b1;
                    sel_incl = 1'b0;
                    sel_one[hit_idx] = 1'b1;
                end
            end
            default: begin
                if (stored[req_cpu] &&
                    ((cur_ep[req_cpu] - old_ep[req_cpu]) == SPAN_MAX)) begin
                    need    = 1'b1;
                    sel_cpu = req_cpu;
                    sel_age = '0;
                end
            end
        endcase

        for (int i = 0; i < LINES; i++) begin
            fmark[i] = sel_one[i] ||
                       (s_q.pend[i] && (s_q.own[i] == sel_cpu) &&
                        (sel_incl ? (age[i] <= sel_age) : (age[i] < sel_age)));
        end

        ready_c   = (s_q.phase == ST_IDLE) && !need;
        acc       = req_valid && ready_c;
        store_vec = '0;
        adv_vec   = '0;

        if (acc && (op == OP_STORE)) begin
            store_vec[req_cpu] = 1'b1;
            if (!hit_any) begin
                s_d.pend[free_idx] = 1'b1;
                s_d.tag[free_idx]  = req_tag;
                s_d.own[free_idx]  = req_cpu;
                s_d.ep[free_idx]   = cur_ep[req_cpu];
            end
        end
        if (acc && (op == OP_BARRIER) && stored[req_cpu]) begin
            adv_vec[req_cpu] = 1'b1;
        end

        // start a drain; an empty mark means wait for the oldest pointer
        if ((s_q.phase == ST_IDLE) && req_valid && need && (|fmark)) begin
            s_d.mark  = fmark;
            s_d.phase = ST_DRAIN;
        end

        if (s_q.phase == ST_DRAIN) begin
            if (pick_any && wb_ready) begin
                s_d.pend[pick_idx] = 1'b0;
                s_d.mark[pick_idx] = 1'b0;
            end
            if (s_d.mark == '0) s_d.phase = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready = ready_c;
    assign wb_valid  = (s_q.phase == ST_DRAIN) && pick_any;
    assign wb_tag    = s_q.tag[pick_idx];
    assign wb_cpu    = s_q.own[pick_idx];
    assign wb_epoch  = s_q.ep[pick_idx];

    // ---------------- assertions ----------------
    logic older_pend;
    always_comb begin
        older_pend = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (s_q.pend[i] && (s_q.own[i] == wb_cpu) && (age[i] < age[pick_idx])) begin
                older_pend = 1'b1;
            end
        end
    end

    // R2: a tag is never pending in two slots at once
    p_tag_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R8: a stalled writeback keeps its fields
    p_wb_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_tag) &&
                                     $stable(wb_cpu) && $stable(wb_epoch)));

    // R11: no writeback overtakes an earlier epoch of the same CPU
    p_wb_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !older_pend);

    // R7: an accepted load leaves the pending set untouched
    p_load_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (op == OP_LOAD)) |=> (s_q.pend == $past(s_q.pend)));
endmodule

// File: tb/pwc_persist_ctrl_test.sv
`timescale 1ns/1ps
module pwc_persist_ctrl_test;
    localparam int TAG_W   = 8;
    localparam int EPOCH_W = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [1:0]         req_op = 2'b00;
    logic [0:0]         req_cpu = 1'b0;
    logic [TAG_W-1:0]   req_tag = '0;
    logic               wb_valid;
    logic               wb_ready = 1'b1;
    logic [TAG_W-1:0]   wb_tag;
    logic [0:0]         wb_cpu;
    logic [EPOCH_W-1:0] wb_epoch;

    pwc_persist_ctrl #(.NCPU(2), .LINES(4), .TAG_W(TAG_W), .EPOCH_W(EPOCH_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_cpu(req_cpu), .req_tag(req_tag),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_tag(wb_tag),
        .wb_cpu(wb_cpu), .wb_epoch(wb_epoch)
    );

    always #2 clk = ~clk;   // 250 MHz

    localparam logic [1:0] ST = 2'b00, LD = 2'b01, BAR = 2'b10, EV = 2'b11;

    int checks = 0;
    int errors = 0;
    int rec_n  = 0;
    logic [TAG_W-1:0]   rec_tag [32];
    logic [0:0]         rec_cpu [32];
    logic [EPOCH_W-1:0] rec_ep  [32];
    logic               stall_en = 1'b0;
    logic               hold_p = 1'b0;
    logic [TAG_W-1:0]   h_tag;
    logic [0:0]         h_cpu;
    logic [EPOCH_W-1:0] h_ep;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // writeback stall pattern
    initial forever begin
        @(negedge clk);
        wb_ready = stall_en ? ~wb_ready : 1'b1;
    end

    // writeback monitor, samples late in the low phase
    initial forever begin
        @(negedge clk);
        #1.5;
        if (rst_n && wb_valid) begin
            if (hold_p) begin
                chk("R8 held tag", int'(wb_tag), int'(h_tag));
                chk("R8 held epoch", int'(wb_epoch), int'(h_ep));
            end
            if (wb_ready) begin
                if (rec_n < 32) begin
                    rec_tag[rec_n] = wb_tag;
                    rec_cpu[rec_n] = wb_cpu;
                    rec_ep[rec_n]  = wb_epoch;
                end
                rec_n++;
                hold_p = 1'b0;
            end else begin
                hold_p = 1'b1;
                h_tag = wb_tag; h_cpu = wb_cpu; h_ep = wb_epoch;
            end
        end else if (hold_p) begin
            chk("R8 valid dropped while stalled", 0, 1);
            hold_p = 1'b0;
        end
    end

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; stall_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rec_n = 0;
        hold_p = 1'b0;
    endtask

    task automatic send(input logic [1:0] op, input logic cpu, input logic [TAG_W-1:0] tag,
                        output int waits);
        req_op = op; req_cpu = cpu; req_tag = tag; req_valid = 1'b1;
        waits = 0;
        #1.5;
        while (!req_ready) begin
            waits++;
            @(negedge clk);
            #1.5;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_wb(input int k, input logic [TAG_W-1:0] tag, input logic cpu,
                          input int ep, input string what);
        chk({what, " tag"}, int'(rec_tag[k]), int'(tag));
        chk({what, " cpu"}, int'(rec_cpu[k]), int'(cpu));
        chk({what, " epoch"}, int'(rec_ep[k]), ep);
    endtask

    task automatic t_reset();
        reset_dut();
        #1.5;
        chk("R1 wb_valid after reset", int'(wb_valid), 0);
        chk("R1 req_ready after reset", int'(req_ready), 1);
        @(negedge clk);
    endtask

    task automatic t_basic();
        int w;
        reset_dut();
        send(ST, 1'b0, 8'h10, w);
        chk("R2 store miss no wait", w, 0);
        send(ST, 1'b0, 8'h11, w);
        send(ST, 1'b0, 8'h10, w);
        chk("R2 same-epoch rewrite no wait", w, 0);
        send(EV, 1'b0, 8'h55, w);
        send(LD, 1'b0, 8'h10, w);
        chk("R7 own load / miss evict no writeback", rec_n, 0);
        send(EV, 1'b0, 8'h11, w);
        chk("R8 evict held not-ready", int'(w > 0), 1);
        chk("R4 single writeback", rec_n, 1);
        chk_wb(0, 8'h11, 1'b0, 0, "R4 victim");
        send(EV, 1'b0, 8'h10, w);
        chk("R4 second evict count", rec_n, 2);
        chk_wb(1, 8'h10, 1'b0, 0, "R4 second victim");
    endtask

    task automatic t_barrier();
        int w;
        reset_dut();
        stall_en = 1'b1;
        send(ST, 1'b0, 8'h20, w);
        send(BAR, 1'b0, 8'h00, w);
        send(BAR, 1'b0, 8'h00, w);
        send(ST, 1'b0, 8'h21, w);
        send(BAR, 1'b0, 8'h00, w);
        send(ST, 1'b0, 8'h22, w);
        send(EV, 1'b0, 8'h22, w);
        chk("R5 chain count", rec_n, 3);
        chk_wb(0, 8'h20, 1'b0, 0, "R5 first");
        chk_wb(1, 8'h21, 1'b0, 1, "R3 empty barrier no advance");
        chk_wb(2, 8'h22, 1'b0, 2, "R5 victim last");
        stall_en = 1'b0;
    endtask

    task automatic t_evict_young();
        int w;
        reset_dut();
        send(ST, 1'b0, 8'h30, w);
        send(BAR, 1'b0, 8'h00, w);
        send(ST, 1'b0, 8'h31, w);
        send(ST, 1'b0, 8'h32, w);
        send(EV, 1'b0, 8'h32, w);
        chk("R5 same epoch line kept", rec_n, 2);
        chk_wb(0, 8'h30, 1'b0, 0, "R5 older first");
        chk_wb(1, 8'h32, 1'b0, 1, "R5 victim");
        send(EV, 1'b0, 8'h31, w);
        chk("R4 remaining line alone", rec_n, 3);
        chk_wb(2, 8'h31, 1'b0, 1, "R4 remaining");
    endtask

    task automatic t_overwrite();
        int w;
        reset_dut();
        send(ST, 1'b0, 8'h40, w);
        send(BAR, 1'b0, 8'h00, w);
        send(ST, 1'b0, 8'h41, w);
        send(BAR, 1'b0, 8'h00, w);
        send(ST, 1'b0, 8'h42, w);
        send(ST, 1'b0, 8'h41, w);
        chk("R6 flush count", rec_n, 2);
        chk_wb(0, 8'h40, 1'b0, 0, "R6 oldest");
        chk_wb(1, 8'h41, 1'b0, 1, "R6 overwritten line");
        send(EV, 1'b0, 8'h41, w);
        chk("R6 reallocated alone", rec_n, 3);
        chk_wb(2, 8'h41, 1'b0, 2, "R6 new epoch");
    endtask

    task automatic t_cross();
        int w;
        reset_dut();
        send(ST, 1'b1, 8'h50, w);
        send(BAR, 1'b1, 8'h00, w);
        send(ST, 1'b1, 8'h51, w);
        send(BAR, 1'b1, 8'h00, w);
        send(ST, 1'b1, 8'h52, w);
        send(LD, 1'b0, 8'h51, w);
        chk("R7 cross load count", rec_n, 2);
        chk_wb(0, 8'h50, 1'b1, 0, "R7 cross first");
        chk_wb(1, 8'h51, 1'b1, 1, "R7 cross hit line");
        send(ST, 1'b0, 8'h52, w);
        chk("R7 cross store count", rec_n, 3);
        chk_wb(2, 8'h52, 1'b1, 2, "R7 cross store");
        send(EV, 1'b0, 8'h52, w);
        chk_wb(3, 8'h52, 1'b0, 0, "R7 new owner");
    endtask

    task automatic t_full();
        int w;
        reset_dut();
        send(ST, 1'b0, 8'h60, w);
        send(BAR, 1'b0, 8'h00, w);
        send(ST, 1'b0, 8'h61, w);
        send(ST, 1'b0, 8'h62, w);
        send(ST, 1'b0, 8'h63, w);
        chk("R9 no flush before full", rec_n, 0);
        send(ST, 1'b0, 8'h64, w);
        chk("R9 full flush count", rec_n, 1);
        chk_wb(0, 8'h60, 1'b0, 0, "R9 slot0 epoch");
        send(EV, 1'b0, 8'h64, w);
        chk("R9 new line alone", rec_n, 2);
        chk_wb(1, 8'h64, 1'b0, 1, "R9 new line");
    endtask

    task automatic t_wrap();
        int w;
        reset_dut();
        send(ST, 1'b0, 8'h70, w);
        send(BAR, 1'b0, 8'h00, w);
        send(ST, 1'b0, 8'h71, w);
        send(BAR, 1'b0, 8'h00, w);
        send(ST, 1'b0, 8'h72, w);
        send(BAR, 1'b0, 8'h00, w);
        send(ST, 1'b0, 8'h73, w);
        send(BAR, 1'b0, 8'h00, w);
        chk("R10 barrier held", int'(w > 0), 1);
        chk("R10 oldest drained", rec_n, 1);
        chk_wb(0, 8'h70, 1'b0, 0, "R10 oldest");
        send(ST, 1'b0, 8'h74, w);
        send(EV, 1'b0, 8'h74, w);
        chk("R11 wrap chain count", rec_n, 5);
        chk_wb(1, 8'h71, 1'b0, 1, "R11 wrap 1");
        chk_wb(2, 8'h72, 1'b0, 2, "R11 wrap 2");
        chk_wb(3, 8'h73, 1'b0, 3, "R11 wrap 3");
        chk_wb(4, 8'h74, 1'b0, 0, "R11 wrapped epoch last");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_barrier();
        t_evict_young();
        t_overwrite();
        t_cross();
        t_full();
        t_wrap();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule